// File: doc/BRIEF.md
# Programmable-Rate Serial Line Transmitter

This block turns bytes into an asynchronous serial line. A 16-bit divisor, supplied as a high byte and a low byte, counts input clocks to make a sub-bit tick. Every serial bit spans sixteen of those ticks. Characters wait in a holding stage until the frame shifter can take them. With `fifo_mode` set, the holding stage queues up to sixteen bytes. With it clear, it keeps a single byte.

Each character goes out as a frame: a low start bit, the data bits least-significant first, an optional parity bit, and then the high stop time. Word length, parity, stop length and break come from plain control inputs. The shifter samples these settings when it takes a character, so later changes affect only later frames. `tx_run` acts as a transmitter-only reset. `thr_empty` reports that the holding stage has nothing left. `tx_empty` also waits for the shifter to finish its last stop bit.

Top module: `sertx_core`

## Requirements
- R1: The sub-bit tick repeats every N input clocks, where N = {div_hi, div_lo} and N is not zero. Every bit of a frame therefore lasts 16·N clocks.
- R2: When frames run back to back, two start edges are separated by exactly (16·(1+W+P)+S)·N clocks. W is the word length, P is 1 when parity is enabled, and S is the stop length in ticks.
- R3: The line idles high. A frame begins with one low start bit, followed by W data bits with the least-significant bit first. `wsel` encodes the word length: 0→5, 1→6, 2→7, 3→8 bits.
- R4: When `par_en`=1, a parity bit follows the data. With `par_odd`=0 it makes the count of ones across data and parity even; with `par_odd`=1 it makes that count odd. When `par_en`=0 no parity bit is sent.
- R5: The stop time is high. It lasts 16 ticks when `stop_long`=0. When `stop_long`=1 it lasts 24 ticks with a 5-bit word and 32 ticks with any other word length.
- R6: With `fifo_mode`=1 the holding stage accepts up to 16 bytes while the shifter is busy. A write that finds it full is dropped.
- R7: With `fifo_mode`=0 the holding stage keeps a single byte. Further writes while it is occupied are dropped.
- R8: `thr_empty` is 1 exactly when no byte waits in the holding stage. It rises once the last queued byte has moved into the shifter, while that frame is still being sent.
- R9: `tx_empty` is 1 only when the holding stage is empty and the shifter has finished its last stop bit. It rises S·N… precisely at the end of the last frame's stop time.
- R10: While `brk`=1, `txd` is driven low whatever the shifter is doing.
- R11: While `tx_run`=0 the transmitter is held in reset: `txd` is high (unless `brk` is set), the holding stage is cleared, writes are ignored, and both empty flags read 1 from the next clock on.
- R12: A divisor of zero stops the tick. A frame in progress freezes, and `txd` keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_run | input | 1 | Transmitter enable; low holds the transmitter in reset |
| div_hi | input | 8 | Divisor high byte |
| div_lo | input | 8 | Divisor low byte |
| fifo_mode | input | 1 | 1: 16-deep holding queue, 0: single holding byte |
| wsel | input | 2 | Word length select (5 + wsel bits) |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | Parity type: 1 odd, 0 even |
| stop_long | input | 1 | Long stop time (1.5 or 2 bits) |
| brk | input | 1 | Force the line low |
| wr_valid | input | 1 | Write strobe for wr_data |
| wr_data | input | 8 | Byte to queue |
| txd | output | 1 | Serial line |
| thr_empty | output | 1 | Holding stage empty |
| tx_empty | output | 1 | Holding stage and shifter both empty |

## Verification
Random batches vary the word length, parity mode, stop length and a divisor of 1 to 3. The data bytes are random, so a wrong bit order, a wrong parity sense or a wrong stop length shows up as a wrong decoded value or a wrong start-to-start spacing. Directed cases use a 5-bit word against wider words with the long stop, which separates the 24-tick stop time from the 32-tick one. A burst of seventeen writes is issued against a single write made while the shifter is busy, which separates the queue depth of FIFO mode from the single-byte holding register. A held zero divisor, break during idle, and writes issued while the transmitter reset is applied show that each of these either freezes or blocks the line without leaving anything queued.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wsel;
    logic       par_en;
    logic       par_odd;
    logic       stop_long;
  } tx_fmt_t;

  // number of data bits for a word-length code
  function automatic logic [3:0] word_bits(input logic [1:0] wsel);
    return 4'd5 + {2'b00, wsel};
  endfunction

  // stop time in sub-bit ticks
  function automatic logic [5:0] stop_len(input logic [1:0] wsel, input logic stop_long);
    if (!stop_long) return 6'd16;
    if (wsel == 2'd0) return 6'd24;
    return 6'd32;
  endfunction

  // parity bit over the active data bits
  function automatic logic par_bit(input logic [DATA_W-1:0] d, input logic [1:0] wsel,
                                   input logic odd);
    logic acc;
    acc = odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(word_bits(wsel))) acc = acc ^ d[i];
    end
    return acc;
  endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic             div_zero;

  assign div_zero = (divisor == '0);
  assign tick     = !div_zero && (cnt_q >= divisor - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || div_zero || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          deep,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] level_q;
  logic [CW-1:0] cap;
  logic          push, pull;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign cap     = deep ? CW'(DEPTH) : CW'(1);
  assign full    = (level_q >= cap);
  assign empty   = (level_q == '0);
  assign push    = wr_en && !full;
  assign pull    = rd_en && !empty;
  assign rd_data = mem[rptr_q];
  assign level   = level_q;

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else if (clr) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (push) wptr_q <= bump(wptr_q);
      if (pull) rptr_q <= bump(rptr_q);
      if (push && !pull)      level_q <= level_q + CW'(1);
      else if (pull && !push) level_q <= level_q - CW'(1);
    end
  end

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  tx_fmt_t           ld_fmt,
  output logic              ready,
  output logic              busy,
  output logic              line
);

  tx_state_e         state_q;
  logic [5:0]        sub_q;
  logic [2:0]        bidx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              par_q;
  tx_fmt_t           fmt_q;

  logic bit_end, last_data, frame_done;

  assign bit_end    = (state_q == ST_STOP) ? (sub_q == stop_len(fmt_q.wsel, fmt_q.stop_long) - 6'd1)
                                           : (sub_q == 6'd15);
  assign last_data  = ({1'b0, bidx_q} == word_bits(fmt_q.wsel) - 4'd1);
  assign frame_done = tick && (state_q == ST_STOP) && bit_end;
  assign ready      = (state_q == ST_IDLE) || frame_done;
  assign busy       = (state_q != ST_IDLE);

  always_comb begin
    case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg_q[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      bidx_q  <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      fmt_q   <= '0;
    end else if (clr) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      bidx_q  <= '0;
    end else if (load) begin
      state_q <= ST_START;
      sub_q   <= '0;
      bidx_q  <= '0;
      shreg_q <= ld_data;
      par_q   <= par_bit(ld_data, ld_fmt.wsel, ld_fmt.par_odd);
      fmt_q   <= ld_fmt;
    end else if (tick && busy) begin
      if (!bit_end) begin
        sub_q <= sub_q + 6'd1;
      end else begin
        sub_q <= '0;
        case (state_q)
          ST_START: state_q <= ST_DATA;
          ST_DATA: begin
            shreg_q <= shreg_q >> 1;
            if (last_data) state_q <= fmt_q.par_en ? ST_PAR : ST_STOP;
            else           bidx_q  <= bidx_q + 3'd1;
          end
          ST_PAR:  state_q <= ST_STOP;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  localparam int HALF = DIV_W / 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_run,
  input  logic [HALF-1:0]   div_hi,
  input  logic [HALF-1:0]   div_lo,
  input  logic              fifo_mode,
  input  logic [1:0]        wsel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop_long,
  input  logic              brk,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              thr_empty,
  output logic              tx_empty
);

  // named internal events, observed by the bound checker
  logic              clr, tick, pop, ready, busy, line;
  logic              hold_empty, hold_full;
  logic [CW-1:0]     hold_level;
  logic [DATA_W-1:0] hold_data;
  logic [DIV_W-1:0]  div_val;
  tx_fmt_t           fmt;

  assign clr     = !tx_run;
  assign div_val = {div_hi, div_lo};
  assign fmt     = '{wsel: wsel, par_en: par_en, par_odd: par_odd, stop_long: stop_long};
  assign pop     = tx_run && ready && !hold_empty;

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .divisor (div_val),
    .tick    (tick)
  );

  sertx_hold #(.DEPTH(DEPTH), .DW(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .deep    (fifo_mode),
    .wr_en   (wr_valid && tx_run),
    .wr_data (wr_data),
    .rd_en   (pop),
    .rd_data (hold_data),
    .empty   (hold_empty),
    .full    (hold_full),
    .level   (hold_level)
  );

  sertx_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .tick    (tick),
    .load    (pop),
    .ld_data (hold_data),
    .ld_fmt  (fmt),
    .ready   (ready),
    .busy    (busy),
    .line    (line)
  );

  assign txd       = brk ? 1'b0 : (tx_run ? line : 1'b1);
  assign thr_empty = hold_empty;
  assign tx_empty  = hold_empty && !busy;

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker #(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_run,
  input logic             brk,
  input logic             wr_valid,
  input logic [DIV_W-1:0] div_val,
  input logic             tick,
  input logic             pop,
  input logic             hold_full,
  input logic [CW-1:0]    hold_level,
  input logic             txd,
  input logic             thr_empty,
  input logic             tx_empty
);

  logic div_zero;
  assign div_zero = (div_val == '0);

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_val > DIV_W'(1)) |=> (!tick || div_val != $past(div_val))); // R1

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (!txd || brk || !tx_run)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && wr_valid && !pop && tx_run) |=> (hold_level == $past(hold_level))); // R6

  AST_EMPTY_NEEDS_THR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> thr_empty); // R9

  AST_RUN_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_run |=> (thr_empty && tx_empty)); // R11

  AST_ZERO_DIV_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (div_zero && !brk && tx_run && !pop) |=> (!(div_zero && !brk && tx_run) || $stable(txd))); // R12

endmodule

bind sertx_core sertx_checker #(.DEPTH(DEPTH), .DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_run     (tx_run),
  .brk        (brk),
  .wr_valid   (wr_valid),
  .div_val    (div_val),
  .tick       (tick),
  .pop        (pop),
  .hold_full  (hold_full),
  .hold_level (hold_level),
  .txd        (txd),
  .thr_empty  (thr_empty),
  .tx_empty   (tx_empty)
);

// File: tb/sim_sertx_core.sv
module sim_sertx_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_run = 1'b1;
  logic [15:0] cfg_div = 16'd1;
  logic       fifo_mode = 1'b1;
  logic [1:0] wsel = 2'd3;
  logic       par_en = 1'b0, par_odd = 1'b0, stop_long = 1'b0, brk = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd, thr_empty, tx_empty;

  int n_cmp = 0, n_bad = 0, cyc = 0, last_rise = 0;
  bit mon_en = 1'b0, done = 1'b0, prev_e = 1'b0;
  int rx_data[$], rx_par[$], rx_stop[$], rx_t[$];
  int exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sertx_core u0 (
    .clk(clk), .rst_n(rst_n), .tx_run(tx_run), .div_hi(cfg_div[15:8]), .div_lo(cfg_div[7:0]),
    .fifo_mode(fifo_mode), .wsel(wsel), .par_en(par_en), .par_odd(par_odd),
    .stop_long(stop_long), .brk(brk), .wr_valid(wr_valid), .wr_data(wr_data),
    .txd(txd), .thr_empty(thr_empty), .tx_empty(tx_empty)
  );

  function automatic int nbits(input logic [1:0] w); return 5 + int'(w); endfunction
  function automatic int stop_ticks(input logic [1:0] w, input logic sl);
    return !sl ? 16 : (w == 2'd0 ? 24 : 32);
  endfunction
  function automatic int frame_ticks(input logic [1:0] w, input logic pe, input logic sl);
    return 16 * (1 + nbits(w) + int'(pe)) + stop_ticks(w, sl);
  endfunction
  function automatic int masked(input int d, input logic [1:0] w);
    return d & ((1 << nbits(w)) - 1);
  endfunction
  function automatic int exp_par(input int d, input logic [1:0] w, input logic odd);
    int ones = $countones(masked(d, w));
    return odd ? ((ones % 2 == 0) ? 1 : 0) : (ones % 2);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // line decoder
  always begin
    @(negedge clk);
    if (mon_en && txd == 1'b0) begin
      int t0, d, nb, k, dv;
      t0 = cyc; d = 0; nb = nbits(wsel); dv = int'(cfg_div);
      for (int b = 0; b < nb; b++) begin
        while (cyc < t0 + (16 * (b + 1) + 8) * dv) @(negedge clk);
        d = d | (int'(txd) << b);
      end
      k = nb + 1;
      if (par_en) begin
        while (cyc < t0 + (16 * k + 8) * dv) @(negedge clk);
        rx_par.push_back(int'(txd));
        k++;
      end else rx_par.push_back(0);
      while (cyc < t0 + (16 * k + 8) * dv) @(negedge clk);
      rx_stop.push_back(int'(txd));
      rx_data.push_back(d);
      rx_t.push_back(t0);
    end
  end

  always @(negedge clk) begin
    if (tx_empty && !prev_e) last_rise = cyc;
    prev_e = tx_empty;
  end

  task automatic put(input int b);
    wr_valid = 1'b1; wr_data = b[7:0];
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!tx_empty) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_rx();
    rx_data.delete(); rx_par.delete(); rx_stop.delete(); rx_t.delete(); exp_q.delete();
  endtask

  task automatic check_batch(input string tag);
    int n, ft;
    ft = frame_ticks(wsel, par_en, stop_long) * int'(cfg_div);
    check(rx_data.size() == exp_q.size(), {tag, " R6 R7 frame count"}, rx_data.size(), exp_q.size());
    n = (rx_data.size() < exp_q.size()) ? rx_data.size() : exp_q.size();
    for (int i = 0; i < n; i++) begin
      check(rx_data[i] == masked(exp_q[i], wsel), {tag, " R3 data"}, rx_data[i], masked(exp_q[i], wsel));
      if (par_en)
        check(rx_par[i] == exp_par(exp_q[i], wsel, par_odd), {tag, " R4 parity"}, rx_par[i],
              exp_par(exp_q[i], wsel, par_odd));
      check(rx_stop[i] == 1, {tag, " R5 stop level"}, rx_stop[i], 1);
      if (i >= 2)
        check(rx_t[i] - rx_t[i-1] == ft, {tag, " R1 R2 R5 start spacing"}, rx_t[i] - rx_t[i-1], ft);
    end
    if (n >= 2)
      check(last_rise - rx_t[n-1] == ft, {tag, " R9 tx_empty timing"}, last_rise - rx_t[n-1], ft);
  endtask

  task automatic run_batch(input int cnt, input string tag);
    bit seen_thr;
    clear_rx();
    for (int i = 0; i < cnt; i++) begin
      int b = int'($urandom_range(255, 0));
      exp_q.push_back(b);
      put(b);
    end
    seen_thr = 1'b0;
    while (!tx_empty) begin
      if (thr_empty && !seen_thr) begin
        seen_thr = 1'b1;
        check(!tx_empty, {tag, " R8 thr_empty before tx_empty"}, int'(tx_empty), 0);
      end
      @(negedge clk);
    end
    check(seen_thr, {tag, " R8 thr_empty seen during last frame"}, int'(seen_thr), 1);
    repeat (4) @(negedge clk);
    check_batch(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R3 reset idle high", int'(txd), 1);
    check(thr_empty && tx_empty, "R8 R9 reset flags", int'({thr_empty, tx_empty}), 3);
    mon_en = 1'b1;

    // directed: 1.5 stop with 5-bit word vs 2 stop with 8-bit word
    wsel = 2'd0; par_en = 1'b1; par_odd = 1'b1; stop_long = 1'b1; cfg_div = 16'd2;
    run_batch(4, "R5 short-word long stop");
    wsel = 2'd3; par_en = 1'b0; stop_long = 1'b1; cfg_div = 16'd1;
    run_batch(4, "R5 wide-word long stop");

    // random batches
    for (int r = 0; r < 10; r++) begin
      wsel = 2'($urandom_range(3, 0));
      par_en = 1'($urandom_range(1, 0));
      par_odd = 1'($urandom_range(1, 0));
      stop_long = 1'($urandom_range(1, 0));
      cfg_div = 16'($urandom_range(3, 1));
      run_batch(int'($urandom_range(5, 3)), "rand");
    end

    // FIFO depth: one in shifter plus 16 queued, 17th extra dropped
    wsel = 2'd3; par_en = 1'b0; stop_long = 1'b0; cfg_div = 16'd1; fifo_mode = 1'b1;
    clear_rx();
    exp_q.push_back(8'h5A); put(8'h5A);
    while (!thr_empty) @(negedge clk);
    for (int i = 0; i < 17; i++) begin
      if (i < 16) exp_q.push_back(i * 13 + 7);
      put(i * 13 + 7);
    end
    check(!thr_empty, "R6 queue holds bytes", int'(thr_empty), 0);
    wait_idle();
    check_batch("R6 overflow");

    // single holding byte
    fifo_mode = 1'b0;
    clear_rx();
    exp_q.push_back(8'hC3); put(8'hC3);
    repeat (3) @(negedge clk);
    exp_q.push_back(8'h3C); put(8'h3C);
    put(8'hFF); put(8'h81);
    wait_idle();
    check_batch("R7 single holder");
    fifo_mode = 1'b1;

    // break during idle
    mon_en = 1'b0;
    brk = 1'b1;
    repeat (2) @(negedge clk);
    check(txd == 1'b0, "R10 break drives low", int'(txd), 0);
    check(tx_empty == 1'b1, "R10 break leaves nothing queued", int'(tx_empty), 1);
    brk = 1'b0;
    @(negedge clk);
    check(txd == 1'b1, "R10 release returns high", int'(txd), 1);

    // zero divisor freezes the start bit
    cfg_div = 16'd0;
    put(8'h77);
    repeat (2) @(negedge clk);
    check(txd == 1'b0 && thr_empty && !tx_empty, "R12 frame taken, start low",
          int'({txd, thr_empty, tx_empty}), 2);
    repeat (300) @(negedge clk);
    check(txd == 1'b0 && !tx_empty, "R12 frozen under zero divisor", int'({txd, tx_empty}), 0);

    // transmitter reset
    tx_run = 1'b0;
    @(negedge clk);
    check(txd == 1'b1 && thr_empty && tx_empty, "R11 reset idles line",
          int'({txd, thr_empty, tx_empty}), 7);
    put(8'h11); put(8'h22);
    tx_run = 1'b1; cfg_div = 16'd2;
    repeat (60) @(negedge clk);
    check(txd == 1'b1 && tx_empty, "R11 writes under reset ignored", int'({txd, tx_empty}), 3);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule